// File: doc/BRIEF.md
# Butterfly Stage Switch Element

This block is one 2x2 switching element of a butterfly interconnect with log2(N) levels, each level holding N/2 such elements. A packet header carries a source address, a destination address and a payload field. The element forms the routing tag as the bitwise XOR of source and destination. It then looks at the single tag bit chosen by the stage index. A zero in that bit keeps the packet on its own side (straight edge). A one moves it to the opposite output (cross edge). Because the decision at every level is fixed by the addresses, each source and destination pair has exactly one path, and a packet crosses every level even when source and destination are equal.

Each input owns one header register. A header is taken when its valid is high and the input's ready is high, and it is presented on its chosen output one clock later. The header is forwarded unchanged. When both registered headers want the same output in the same cycle, input 0 is forwarded and input 1 keeps its header, raises the blocked flag and drops its ready. It leaves on the first cycle in which it no longer collides. A parameter chooses whether stage i examines tag bit i (least significant first) or bit ADDR_W-1-i.

Top module: `bfly_sw2`

## Requirements
- R1: While reset is held and on the first cycle after it, out_vld is 00, blocked is 0 and in_rdy is 11.
- R2: A header taken at a clock edge (in_vld[i] and in_rdy[i] high) appears on exactly one output after that edge, bit-for-bit unchanged. Header layout: source in bits [ADDR_W-1:0], destination in bits [2*ADDR_W-1:ADDR_W], payload above.
- R3: With the default bit order, if bit stage_idx of source XOR destination is 0, input i's header leaves on output i (straight).
- R4: If that bit is 1, input i's header leaves on output 1-i (cross).
- R5: A header whose source equals its destination takes the straight output at every stage.
- R6: When both registered headers want the same output, input 0's header is forwarded, blocked is 1, in_rdy[1] is 0 and only one output is valid.
- R7: A header held by a conflict leaves on its chosen output in the next cycle that has no conflict.
- R8: When both registered headers want different outputs, both are forwarded in the same cycle and blocked stays 0.
- R9: Chaining the per-stage decisions for stages 0 to 3 of a 16-node network moves every one of the 256 source/destination pairs to its destination.
- R10: A new header offered on input 1 while it is blocked (in_rdy[1] low) is ignored; the held header is not overwritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| stage_idx | input | SIDX_W | Level of this element, selects the tag bit |
| in_vld | input | 2 | Header offered on input 1 / input 0 |
| in_hdr0 | input | HDR_W | Header on input 0 |
| in_hdr1 | input | HDR_W | Header on input 1 |
| in_rdy | output | 2 | Input may take a header at the next edge |
| out_vld | output | 2 | Header present on output 1 / output 0 |
| out_hdr0 | output | HDR_W | Header on output 0 (straight side of input 0) |
| out_hdr1 | output | HDR_W | Header on output 1 (straight side of input 1) |
| blocked | output | 1 | Input 1 lost a conflict and holds its header |

## Verification
The functions that share a cycle are conflict resolution and acceptance on input 1: a losing header must be held in the same cycle that a new header may be offered behind it. The bench provokes this by driving two headers that route to the same output, then offering a different header on input 1 while blocked is high. It judges the outcome by seeing input 0's header forwarded, the held header leaving one cycle later on the correct output, and the offered header never appearing on any output.

// File: rtl/bfly_pkg.sv
package bfly_pkg;

   typedef enum logic {
      ORD_LSB_FIRST = 1'b0,
      ORD_MSB_FIRST = 1'b1
   } bit_order_e;

   // output port reached from input side in_side when the cross edge is (not) taken
   function automatic logic dest_port(input logic in_side, input logic take_cross);
      return in_side ^ take_cross;
   endfunction

endpackage

// File: rtl/bfly_tag_pick.sv
module bfly_tag_pick
   import bfly_pkg::*;
#(
   parameter int         ADDR_W = 4,
   parameter int         SIDX_W = 2,
   parameter bit_order_e ORDER  = ORD_LSB_FIRST
) (
   input  logic [ADDR_W-1:0] src,
   input  logic [ADDR_W-1:0] dst,
   input  logic [SIDX_W-1:0] stage_idx,
   output logic              take_cross
);
   logic [ADDR_W-1:0] tag;
   logic [ADDR_W-1:0] tag_ord;

   assign tag = src ^ dst;

   generate
      if (ORDER == ORD_LSB_FIRST) begin : g_lsb
         assign tag_ord = tag;
      end else begin : g_msb
         for (genvar b = 0; b < ADDR_W; b++) begin : g_rev
            assign tag_ord[b] = tag[ADDR_W-1-b];
         end
      end
   endgenerate

   always_comb begin
      take_cross = 1'b0;
      for (int k = 0; k < ADDR_W; k++) begin
         if (int'(stage_idx) == k) take_cross = tag_ord[k];
      end
   end
endmodule

// File: rtl/bfly_hdr_slot.sv
module bfly_hdr_slot #(
   parameter int HDR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_vld,
   input  logic [HDR_W-1:0] in_hdr,
   input  logic             drain,
   output logic             in_rdy,
   output logic             slot_vld,
   output logic [HDR_W-1:0] slot_hdr
);
   assign in_rdy = !slot_vld || drain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_vld <= 1'b0;
         slot_hdr <= '0;
      end else begin
         if (in_vld && in_rdy) begin
            slot_vld <= 1'b1;
            slot_hdr <= in_hdr;
         end else if (drain) begin
            slot_vld <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/bfly_pair_arb.sv
module bfly_pair_arb
   import bfly_pkg::*;
#(
   parameter int HDR_W = 16
) (
   input  logic [1:0]       slot_vld,
   input  logic [1:0]       take_cross,
   input  logic [HDR_W-1:0] hdr0,
   input  logic [HDR_W-1:0] hdr1,
   output logic [1:0]       drain,
   output logic [1:0]       out_vld,
   output logic [HDR_W-1:0] out_hdr0,
   output logic [HDR_W-1:0] out_hdr1,
   output logic             clash
);
   logic [1:0]       want;
   logic [HDR_W-1:0] sel_hdr [2];

   assign want[0] = dest_port(1'b0, take_cross[0]);
   assign want[1] = dest_port(1'b1, take_cross[1]);

   // input 0 has fixed priority
   assign clash    = slot_vld[0] && slot_vld[1] && (want[0] == want[1]);
   assign drain[0] = slot_vld[0];
   assign drain[1] = slot_vld[1] && !clash;

   generate
      for (genvar p = 0; p < 2; p++) begin : g_port
         logic from0;
         logic from1;
         assign from0      = drain[0] && (want[0] == 1'(p));
         assign from1      = drain[1] && (want[1] == 1'(p));
         assign out_vld[p] = from0 || from1;
         assign sel_hdr[p] = from0 ? hdr0 : (from1 ? hdr1 : '0);
      end
   endgenerate

   assign out_hdr0 = sel_hdr[0];
   assign out_hdr1 = sel_hdr[1];
endmodule

// File: rtl/bfly_sw2.sv
module bfly_sw2
   import bfly_pkg::*;
#(
   parameter int         ADDR_W    = 4,
   parameter int         PAYLOAD_W = 8,
   parameter bit_order_e ORDER     = ORD_LSB_FIRST,
   localparam int        HDR_W     = 2*ADDR_W + PAYLOAD_W,
   localparam int        SIDX_W    = (ADDR_W > 1) ? $clog2(ADDR_W) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SIDX_W-1:0] stage_idx,
   input  logic [1:0]        in_vld,
   input  logic [HDR_W-1:0]  in_hdr0,
   input  logic [HDR_W-1:0]  in_hdr1,
   output logic [1:0]        in_rdy,
   output logic [1:0]        out_vld,
   output logic [HDR_W-1:0]  out_hdr0,
   output logic [HDR_W-1:0]  out_hdr1,
   output logic              blocked
);
   generate
      if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr
         $error("bfly_sw2: ADDR_W must lie in 1..16");
      end
      if (PAYLOAD_W < 1) begin : g_bad_pay
         $error("bfly_sw2: PAYLOAD_W must be at least 1");
      end
   endgenerate

   logic [HDR_W-1:0] in_hdr [2];
   logic [HDR_W-1:0] slot_hdr [2];
   logic [1:0]       slot_vld;
   logic [1:0]       take_cross;
   logic [1:0]       drain;

   assign in_hdr[0] = in_hdr0;
   assign in_hdr[1] = in_hdr1;

   generate
      for (genvar i = 0; i < 2; i++) begin : g_in
         bfly_hdr_slot #(.HDR_W(HDR_W)) i_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_vld   (in_vld[i]),
            .in_hdr   (in_hdr[i]),
            .drain    (drain[i]),
            .in_rdy   (in_rdy[i]),
            .slot_vld (slot_vld[i]),
            .slot_hdr (slot_hdr[i])
         );

         bfly_tag_pick #(.ADDR_W(ADDR_W), .SIDX_W(SIDX_W), .ORDER(ORDER)) i_tag (
            .src        (slot_hdr[i][ADDR_W-1:0]),
            .dst        (slot_hdr[i][2*ADDR_W-1:ADDR_W]),
            .stage_idx  (stage_idx),
            .take_cross (take_cross[i])
         );
      end
   endgenerate

   bfly_pair_arb #(.HDR_W(HDR_W)) i_arb (
      .slot_vld   (slot_vld),
      .take_cross (take_cross),
      .hdr0       (slot_hdr[0]),
      .hdr1       (slot_hdr[1]),
      .drain      (drain),
      .out_vld    (out_vld),
      .out_hdr0   (out_hdr0),
      .out_hdr1   (out_hdr1),
      .clash      (blocked)
   );
endmodule

// File: rtl/bfly_sw2_chk.sv
module bfly_sw2_chk #(
   parameter int HDR_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       in_vld,
   input logic [1:0]       in_rdy,
   input logic [HDR_W-1:0] in_hdr0,
   input logic [1:0]       out_vld,
   input logic [HDR_W-1:0] out_hdr0,
   input logic [HDR_W-1:0] out_hdr1,
   input logic             blocked,
   input logic             held_vld,
   input logic [HDR_W-1:0] held_hdr
);
   assert_in0_leaves_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld[0] && in_rdy[0]) |=> (out_vld != 2'b00));

   assert_hdr_intact_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld[0] && in_rdy[0]) |=>
         ((out_vld[0] && out_hdr0 == $past(in_hdr0)) ||
          (out_vld[1] && out_hdr1 == $past(in_hdr0))));

   assert_one_winner_R6: assert property (@(posedge clk) disable iff (!rst_n)
      blocked |-> ($countones(out_vld) == 1));

   assert_loser_stalls_R6: assert property (@(posedge clk) disable iff (!rst_n)
      blocked |-> !in_rdy[1]);

   assert_held_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
      blocked |=> (held_vld && $stable(held_hdr)));
endmodule

bind bfly_sw2 bfly_sw2_chk #(.HDR_W(HDR_W)) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_vld   (in_vld),
   .in_rdy   (in_rdy),
   .in_hdr0  (in_hdr0),
   .out_vld  (out_vld),
   .out_hdr0 (out_hdr0),
   .out_hdr1 (out_hdr1),
   .blocked  (blocked),
   .held_vld (slot_vld[1]),
   .held_hdr (slot_hdr[1])
);

// File: tb/test_bfly_sw2.sv
module test_bfly_sw2;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 4;
   localparam int HW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    stage_idx = '0;
   logic [1:0]    in_vld = '0;
   logic [HW-1:0] in_hdr0 = '0;
   logic [HW-1:0] in_hdr1 = '0;
   logic [1:0]    in_rdy;
   logic [1:0]    out_vld;
   logic [HW-1:0] out_hdr0;
   logic [HW-1:0] out_hdr1;
   logic          blocked;

   int total = 0;
   int bad   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bfly_sw2 #(.ADDR_W(AW), .PAYLOAD_W(8)) i_bfly_sw2 (
      .clk(clk), .rst_n(rst_n), .stage_idx(stage_idx),
      .in_vld(in_vld), .in_hdr0(in_hdr0), .in_hdr1(in_hdr1),
      .in_rdy(in_rdy), .out_vld(out_vld),
      .out_hdr0(out_hdr0), .out_hdr1(out_hdr1), .blocked(blocked)
   );

   // header = {payload[15:8], dst[7:4], src[3:0]}
   typedef struct packed {
      logic [1:0]    stg;
      logic [1:0]    v;
      logic [HW-1:0] h0;
      logic [HW-1:0] h1;
      logic [1:0]    eov;
      logic [HW-1:0] eo0;
      logic [HW-1:0] eo1;
      logic          eblk;
      logic [1:0]    dv;
      logic [HW-1:0] dh;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VECS [NV] = '{
      '{2'd0, 2'b01, 16'hA130, 16'h0000, 2'b10, 16'h0000, 16'hA130, 1'b0, 2'b00, 16'h0000},
      '{2'd2, 2'b01, 16'hA230, 16'h0000, 2'b01, 16'hA230, 16'h0000, 1'b0, 2'b00, 16'h0000},
      '{2'd1, 2'b10, 16'h0000, 16'hB252, 2'b01, 16'hB252, 16'h0000, 1'b0, 2'b00, 16'h0000},
      '{2'd3, 2'b10, 16'h0000, 16'hB3F7, 2'b01, 16'hB3F7, 16'h0000, 1'b0, 2'b00, 16'h0000},
      '{2'd0, 2'b11, 16'hC144, 16'hD199, 2'b11, 16'hC144, 16'hD199, 1'b0, 2'b00, 16'h0000},
      '{2'd1, 2'b11, 16'hC220, 16'hD213, 2'b11, 16'hD213, 16'hC220, 1'b0, 2'b00, 16'h0000},
      '{2'd0, 2'b11, 16'hE155, 16'hE210, 2'b01, 16'hE155, 16'h0000, 1'b1, 2'b01, 16'hE210},
      '{2'd3, 2'b11, 16'hF180, 16'hF2FF, 2'b10, 16'h0000, 16'hF180, 1'b1, 2'b10, 16'hF2FF},
      '{2'd2, 2'b00, 16'h0000, 16'h0000, 2'b00, 16'h0000, 16'h0000, 1'b0, 2'b00, 16'h0000}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [HW-1:0] port_hdr(input logic p);
      return p ? out_hdr1 : out_hdr0;
   endfunction

   initial begin
      #(CLK_PERIOD * 100000);
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (2) @(negedge clk);
      check("R1 out_vld in reset", 32'(out_vld), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 out_vld", 32'(out_vld), 32'd0);
      check("R1 blocked", 32'(blocked), 32'd0);
      check("R1 in_rdy", 32'(in_rdy), 32'd3);

      // table: R2 R3 R4 R5 R6 R7 R8
      for (int n = 0; n < NV; n++) begin
         stage_idx = VECS[n].stg;
         in_vld    = VECS[n].v;
         in_hdr0   = VECS[n].h0;
         in_hdr1   = VECS[n].h1;
         @(negedge clk);
         check($sformatf("R3 R4 R8 vec%0d out_vld", n), 32'(out_vld), 32'(VECS[n].eov));
         if (VECS[n].eov[0]) check($sformatf("R2 vec%0d out_hdr0", n), 32'(out_hdr0), 32'(VECS[n].eo0));
         if (VECS[n].eov[1]) check($sformatf("R2 vec%0d out_hdr1", n), 32'(out_hdr1), 32'(VECS[n].eo1));
         check($sformatf("R6 vec%0d blocked", n), 32'(blocked), 32'(VECS[n].eblk));
         if (VECS[n].eblk) check($sformatf("R6 vec%0d in_rdy1", n), 32'(in_rdy[1]), 32'd0);
         in_vld = 2'b00;
         @(negedge clk);
         check($sformatf("R7 vec%0d drain out_vld", n), 32'(out_vld), 32'(VECS[n].dv));
         if (VECS[n].dv != 2'b00)
            check($sformatf("R7 vec%0d drain hdr", n), 32'(port_hdr(VECS[n].dv[1])), 32'(VECS[n].dh));
      end

      // R10: offer a new header on input 1 while it is blocked
      stage_idx = 2'd0;
      in_vld    = 2'b11;
      in_hdr0   = 16'h1155;
      in_hdr1   = 16'h2210;
      @(negedge clk);
      check("R10 blocked set", 32'(blocked), 32'd1);
      in_vld  = 2'b10;
      in_hdr1 = 16'h3377;
      @(negedge clk);
      in_vld = 2'b00;
      check("R10 held hdr leaves", 32'(out_hdr0), 32'h2210);
      check("R10 held vld", 32'(out_vld), 32'd1);
      @(negedge clk);
      check("R10 offered hdr dropped", 32'(out_vld), 32'd0);

      // R9 / R5: chain all stages for all 16x16 pairs
      for (int s = 0; s < 16; s++) begin
         for (int d = 0; d < 16; d++) begin
            logic [3:0] pos;
            logic [HW-1:0] h;
            logic ok_hdr;
            logic all_straight;
            pos = 4'(s);
            h = {8'(s*16+d), 4'(d), 4'(s)};
            ok_hdr = 1'b1;
            all_straight = 1'b1;
            for (int st = 0; st < AW; st++) begin
               logic side;
               logic outp;
               side = pos[st];
               stage_idx = 2'(st);
               in_vld = side ? 2'b10 : 2'b01;
               in_hdr0 = side ? 16'h0 : h;
               in_hdr1 = side ? h : 16'h0;
               @(negedge clk);
               in_vld = 2'b00;
               outp = out_vld[1];
               if ($countones(out_vld) != 1 || port_hdr(outp) !== h) ok_hdr = 1'b0;
               if (outp != side) all_straight = 1'b0;
               pos[st] = outp;
            end
            check($sformatf("R9 pair %0d->%0d dest", s, d), 32'(pos), 32'(d));
            check($sformatf("R2 pair %0d->%0d hdr", s, d), 32'(ok_hdr), 32'd1);
            if (s == d) check($sformatf("R5 pair %0d straight", s), 32'(all_straight), 32'd1);
         end
      end

      @(negedge clk);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule